// File: doc/BRIEF.md
# Memory Self-Test Pattern Fill Engine

This engine sweeps an 8 KB byte-wide buffer RAM once. Each clock cycle it writes one generated byte, starting at address 0x0000 and ending at 0x1FFF. While it writes, it keeps a 16-bit Internet-style checksum of the stream. A separate reader can later sum the memory contents and compare its result with that checksum. Three generators are available:

- a pseudo-random byte sequence from an 8-bit LFSR;
- the low byte of each address;
- a seed byte that is rotated left by a programmable amount before every write after the first.

The host loads a seed byte and a configuration (fill mode, rotate amount, RAM port select). It then pulses a start request while the level `test_en` is high. The busy flag stands in for a start bit that clears itself when the sweep completes. The sweep is aborted if the host pulses an abort or drops `test_en`. A random-mode run writes its final LFSR state back into the seed register, so the next run either continues the sequence or is repeated by reloading the same seed.

Top module: `mbist_fill`

## Requirements
- R1: After an accepted start, `busy_o` is high for exactly 8192 cycles. In each of those cycles the engine writes one byte, in ascending address order from 0x0000 to 0x1FFF.
- R2: Random mode (`cfg_mode` = 2'b00) writes the seed at address 0. Each later byte is the previous byte shifted left by one, with the new bit 0 equal to bit7^bit5^bit4^bit3 of the previous byte. At the end of the sweep the seed register holds the next value in that sequence after the last byte written.
- R3: In random mode a zero seed fills the buffer with zeros and leaves the seed at zero. Two runs with the same seed and mode produce identical data and an identical checksum.
- R4: Address mode (`cfg_mode` = 2'b01, and 2'b11 behaves the same) writes the low byte of each address. The seed does not affect the data, and the seed register is not changed. A full sweep gives a checksum of 0xF807.
- R5: Shift mode (`cfg_mode` = 2'b10) writes the seed at address 0. Each later byte is the previous byte rotated left by `cfg_shift` (0 to 7), with bits leaving bit 7 re-entering at bit 0. The seed register is not changed.
- R6: The checksum adds the bytes in pairs as 16-bit words, with the even address as the high byte. The sum uses one's-complement arithmetic with end-around carry, and the result is inverted. It appears on `csum_o` in the first cycle that `busy_o` is low after a completed sweep.
- R7: If `start_clr` is high, or `test_en` is low, during a busy cycle, no write occurs in that cycle and `busy_o` is low in the next cycle. `csum_o` and the seed register keep their values from before the run.
- R8: `cfg_port_sel` = 0 routes the writes to port A and 1 routes them to port B. The unselected port never asserts its write enable.
- R9: Configuration and seed writes are taken only when the engine is idle and no start is accepted in the same cycle. While busy, these writes change neither the fill nor the final seed.
- R10: A start request is ignored while `test_en` is low, or while `start_clr` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_en | input | 1 | Test enable level; low aborts a run |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Fill mode: 00 random, 01/11 address, 10 shift |
| cfg_shift | input | 3 | Rotate-left amount for shift mode |
| cfg_port_sel | input | 1 | RAM port select (0 = A, 1 = B) |
| seed_we | input | 1 | Seed register write strobe |
| seed_wdata | input | 8 | Seed write data |
| start_set | input | 1 | Start request pulse |
| start_clr | input | 1 | Abort request pulse |
| busy_o | output | 1 | Run in progress (self-clearing start bit) |
| seed_o | output | 8 | Seed register contents |
| csum_o | output | 16 | Checksum of the last completed sweep |
| ram_a_addr | output | 13 | Port A address |
| ram_a_wdata | output | 8 | Port A write data |
| ram_a_we | output | 1 | Port A write enable |
| ram_b_addr | output | 13 | Port B address |
| ram_b_wdata | output | 8 | Port B write data |
| ram_b_we | output | 1 | Port B write enable |

## Verification
Two pairs of events can fall in the same clock cycle.

- An abort can arrive in the same cycle as a pending write. The bench raises `start_clr`, or lowers `test_en`, partway through a sweep. In that same cycle it checks that neither write enable is active. One cycle later it checks that busy has dropped and that the checksum and seed still hold their earlier values.
- A configuration or seed write can coincide with a running fill. The bench writes a different mode and seed in the middle of a sweep. It then judges the whole byte stream and the final seed against the values predicted from the original settings.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [1:0] {
        FILL_RAND     = 2'b00,
        FILL_ADDR     = 2'b01,
        FILL_SHIFT    = 2'b10,
        FILL_ADDR_ALT = 2'b11
    } fill_mode_e;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 16;

    // one step of the 8-bit Fibonacci register, taps 8,6,5,4
    function automatic logic [BYTE_W-1:0] lfsr_step(input logic [BYTE_W-1:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    function automatic logic [BYTE_W-1:0] rot_left(input logic [BYTE_W-1:0] v,
                                                   input logic [2:0] n);
        logic [2*BYTE_W-1:0] dbl;
        dbl = {v, v} << n;
        return dbl[2*BYTE_W-1:BYTE_W];
    endfunction

    // 16-bit add with end-around carry
    function automatic logic [WORD_W-1:0] ones_add(input logic [WORD_W-1:0] a,
                                                   input logic [WORD_W-1:0] b);
        logic [WORD_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, s[WORD_W]};
    endfunction

    function automatic logic is_addr_mode(input fill_mode_e m);
        return (m == FILL_ADDR) || (m == FILL_ADDR_ALT);
    endfunction

endpackage

// File: rtl/mbist_pattern_gen.sv
module mbist_pattern_gen
    import mbist_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    input  fill_mode_e        mode_i,
    input  logic [2:0]        shamt_i,
    input  logic [BYTE_W-1:0] seed_i,
    output logic [BYTE_W-1:0] pat_o,
    output logic [BYTE_W-1:0] next_o
);
    logic [BYTE_W-1:0] pat_d, pat_q;
    logic [BYTE_W-1:0] step;

    always_comb begin
        unique case (mode_i)
            FILL_RAND:  step = lfsr_step(pat_q);
            FILL_SHIFT: step = rot_left(pat_q, shamt_i);
            default:    step = pat_q;
        endcase
        pat_d = pat_q;
        if (load_i)     pat_d = seed_i;
        else if (adv_i) pat_d = step;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pat_q <= '0;
        else        pat_q <= pat_d;
    end

    assign pat_o  = pat_q;
    assign next_o = step;

    // R3
    zero_seed_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && mode_i == FILL_RAND && pat_q == '0) |=> (pat_q == '0));

endmodule

// File: rtl/mbist_csum_acc.sv
module mbist_csum_acc
    import mbist_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic              odd_i,
    input  logic              last_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [WORD_W-1:0] csum_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [WORD_W-1:0] acc;
        logic [WORD_W-1:0] res;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [WORD_W-1:0] summed;

    always_comb begin
        summed = ones_add(acc_q.acc, {acc_q.hi, byte_i});
        acc_d  = acc_q;
        if (clr_i) begin
            acc_d.acc = '0;
            acc_d.hi  = '0;
        end else if (en_i) begin
            if (!odd_i) begin
                acc_d.hi = byte_i;
            end else begin
                acc_d.acc = summed;
                if (last_i) acc_d.res = ~summed;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign csum_o = acc_q.res;

    // R6
    even_byte_no_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !odd_i && !clr_i) |=> $stable(acc_q.acc));

    // R6
    result_only_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_i && last_i) |=> $stable(acc_q.res));

endmodule

// File: rtl/mbist_port_mux.sv
module mbist_port_mux
    import mbist_pkg::*;
#(
    parameter int unsigned ADDR_W  = 13,
    parameter int unsigned N_PORTS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_i,
    input  logic                      sel_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [BYTE_W-1:0]         data_i,
    output logic [N_PORTS-1:0]        we_o,
    output logic [N_PORTS-1:0][ADDR_W-1:0] addr_o,
    output logic [N_PORTS-1:0][BYTE_W-1:0] data_o
);
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        assign we_o[p]   = wr_i && (sel_i == p[0]);
        assign addr_o[p] = addr_i;
        assign data_o[p] = data_i;
    end

    // R8
    single_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_o));

endmodule

// File: rtl/mbist_fill.sv
module mbist_fill
    import mbist_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_en,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_mode,
    input  logic [2:0]        cfg_shift,
    input  logic              cfg_port_sel,
    input  logic              seed_we,
    input  logic [7:0]        seed_wdata,
    input  logic              start_set,
    input  logic              start_clr,
    output logic              busy_o,
    output logic [7:0]        seed_o,
    output logic [15:0]       csum_o,
    output logic [ADDR_W-1:0] ram_a_addr,
    output logic [7:0]        ram_a_wdata,
    output logic              ram_a_we,
    output logic [ADDR_W-1:0] ram_b_addr,
    output logic [7:0]        ram_b_wdata,
    output logic              ram_b_we
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
    localparam int unsigned       N_PORTS   = 2;

    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] idx;
        fill_mode_e        mode;
        logic [2:0]        shamt;
        logic              psel;
        logic [BYTE_W-1:0] seed;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic              abort, launch, wr_en, last_wr;
    logic [BYTE_W-1:0] pat, pat_next, wr_byte;
    logic [N_PORTS-1:0]             p_we;
    logic [N_PORTS-1:0][ADDR_W-1:0] p_addr;
    logic [N_PORTS-1:0][BYTE_W-1:0] p_data;

    always_comb begin
        abort   = ctrl_q.busy && (start_clr || !test_en);
        launch  = !ctrl_q.busy && start_set && !start_clr && test_en;
        wr_en   = ctrl_q.busy && !abort;
        last_wr = wr_en && (ctrl_q.idx == LAST_ADDR);
        wr_byte = is_addr_mode(ctrl_q.mode) ? ctrl_q.idx[BYTE_W-1:0] : pat;

        ctrl_d = ctrl_q;
        if (!ctrl_q.busy && !launch) begin
            if (cfg_we) begin
                ctrl_d.mode  = fill_mode_e'(cfg_mode);
                ctrl_d.shamt = cfg_shift;
                ctrl_d.psel  = cfg_port_sel;
            end
            if (seed_we) ctrl_d.seed = seed_wdata;
        end
        if (launch) begin
            ctrl_d.busy = 1'b1;
            ctrl_d.idx  = '0;
        end
        if (wr_en) begin
            ctrl_d.idx = ctrl_q.idx + 1'b1;
            if (last_wr) begin
                ctrl_d.busy = 1'b0;
                if (ctrl_q.mode == FILL_RAND) ctrl_d.seed = pat_next;
            end
        end
        if (abort) ctrl_d.busy = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '{busy: 1'b0, idx: '0, mode: FILL_RAND,
                                shamt: 3'd0, psel: 1'b0, seed: '0};
        else        ctrl_q <= ctrl_d;
    end

    mbist_pattern_gen u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (launch),
        .adv_i   (wr_en),
        .mode_i  (ctrl_q.mode),
        .shamt_i (ctrl_q.shamt),
        .seed_i  (ctrl_q.seed),
        .pat_o   (pat),
        .next_o  (pat_next)
    );

    mbist_csum_acc u_csum (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (launch),
        .en_i   (wr_en),
        .odd_i  (ctrl_q.idx[0]),
        .last_i (last_wr),
        .byte_i (wr_byte),
        .csum_o (csum_o)
    );

    mbist_port_mux #(.ADDR_W(ADDR_W), .N_PORTS(N_PORTS)) u_mux (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_en),
        .sel_i  (ctrl_q.psel),
        .addr_i (ctrl_q.idx),
        .data_i (wr_byte),
        .we_o   (p_we),
        .addr_o (p_addr),
        .data_o (p_data)
    );

    assign busy_o      = ctrl_q.busy;
    assign seed_o      = ctrl_q.seed;
    assign ram_a_we    = p_we[0];
    assign ram_a_addr  = p_addr[0];
    assign ram_a_wdata = p_data[0];
    assign ram_b_we    = p_we[1];
    assign ram_b_addr  = p_addr[1];
    assign ram_b_wdata = p_data[1];

    // R1
    done_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.busy && ctrl_q.idx == LAST_ADDR) |=> !ctrl_q.busy);

    // R4
    addr_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ram_a_we || ram_b_we) && is_addr_mode(ctrl_q.mode))
            |-> (ram_a_wdata == ram_a_addr[BYTE_W-1:0]));

    // R9
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.busy && $past(ctrl_q.busy))
            |-> ($stable(ctrl_q.mode) && $stable(ctrl_q.shamt) && $stable(ctrl_q.psel)));

    // R7
    abort_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.busy && start_clr) |-> !(ram_a_we || ram_b_we));

endmodule

// File: tb/mbist_fill_tb.sv
module mbist_fill_tb;
    localparam int N = 8192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_en = 1'b0, cfg_we = 1'b0, cfg_port_sel = 1'b0, seed_we = 1'b0;
    logic start_set = 1'b0, start_clr = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic [2:0] cfg_shift = 3'd0;
    logic [7:0] seed_wdata = 8'h00;
    logic busy_o, ram_a_we, ram_b_we;
    logic [7:0] seed_o, ram_a_wdata, ram_b_wdata;
    logic [15:0] csum_o;
    logic [12:0] ram_a_addr, ram_b_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] exp_mem [N];

    always #5 clk = ~clk;

    mbist_fill u_dut (.*);

    function automatic logic [7:0] m_lfsr(input logic [7:0] s);
        logic fb;
        fb = s[7] ^ s[5] ^ s[4] ^ s[3];
        return {s[6:0], fb};
    endfunction

    function automatic logic [7:0] m_rot(input logic [7:0] v, input int n);
        logic [7:0] r;
        r = v;
        for (int k = 0; k < n; k++) r = {r[6:0], r[7]};
        return r;
    endfunction

    function automatic logic [15:0] m_csum();
        longint unsigned s;
        s = 0;
        for (int a = 0; a < N; a += 2) s += {exp_mem[a], exp_mem[a+1]};
        while (s >> 16) s = (s & 64'hFFFF) + (s >> 16);
        return ~s[15:0];
    endfunction

    task automatic build(input logic [1:0] m, input logic [2:0] sh,
                         input logic [7:0] sd, output logic [7:0] seed_after);
        logic [7:0] v;
        v = sd;
        for (int a = 0; a < N; a++) begin
            if (m == 2'b01 || m == 2'b11) exp_mem[a] = a[7:0];
            else exp_mem[a] = v;
            if (m == 2'b00) v = m_lfsr(v);
            else if (m == 2'b10) v = m_rot(v, int'(sh));
        end
        seed_after = (m == 2'b00) ? v : sd;
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Full sweep: program, start, check every write, checksum and seed.
    task automatic run_fill(input logic [1:0] m, input logic [2:0] sh, input logic ps,
                            input logic [7:0] sd, input bit disturb, input string req,
                            output logic [15:0] cs);
        logic [7:0] seed_exp;
        int bad, first_i;
        logic [7:0] act_d;
        @(negedge clk);
        cfg_we = 1; cfg_mode = m; cfg_shift = sh; cfg_port_sel = ps;
        seed_we = 1; seed_wdata = sd;
        @(negedge clk);
        cfg_we = 0; seed_we = 0; start_set = 1;
        build(m, sh, sd, seed_exp);
        @(negedge clk);
        start_set = 0;
        bad = 0; first_i = -1; act_d = 0;
        for (int i = 0; i < N; i++) begin
            logic we_sel, we_oth;
            logic [12:0] ad;
            logic [7:0] dt;
            we_sel = ps ? ram_b_we : ram_a_we;
            we_oth = ps ? ram_a_we : ram_b_we;
            ad = ps ? ram_b_addr : ram_a_addr;
            dt = ps ? ram_b_wdata : ram_a_wdata;
            if (!busy_o || !we_sel || we_oth || ad != i[12:0] || dt != exp_mem[i]) begin
                if (first_i < 0) begin first_i = i; act_d = dt; end
                bad++;
            end
            // R9: mid-run config/seed writes must be ignored
            cfg_we = disturb && (i == 100);
            seed_we = disturb && (i == 100);
            cfg_mode = disturb ? ~m : m;
            seed_wdata = disturb ? ~sd : sd;
            cfg_port_sel = disturb ? ~ps : ps;
            @(negedge clk);
        end
        cfg_we = 0; seed_we = 0;
        // R1 R2 R4 R5 R8: whole stream
        chk(bad == 0, {req, " R1 R8 stream"}, first_i < 0 ? 0 : act_d,
            first_i < 0 ? 0 : exp_mem[first_i]);
        // R1: busy drops right after the last write
        chk(!busy_o, "R1 busy clear", busy_o, 0);
        // R6
        chk(csum_o == m_csum(), {req, " R6 checksum"}, csum_o, m_csum());
        chk(seed_o == seed_exp, {req, " seed after"}, seed_o, seed_exp);
        cs = csum_o;
    endtask

    initial begin
        logic [15:0] cs1, cs2, cs_prev;
        logic [7:0] seed_prev;
        repeat (3) @(negedge clk);
        // reset state
        chk(busy_o == 0 && ram_a_we == 0 && ram_b_we == 0, "R1 reset idle", busy_o, 0);
        chk(csum_o == 16'h0 && seed_o == 8'h0, "R6 reset values", csum_o, 0);
        rst_n = 1;
        @(negedge clk);

        // R10: start with enable low is ignored
        start_set = 1;
        @(negedge clk);
        start_set = 0;
        chk(!busy_o && !ram_a_we && !ram_b_we, "R10 start without enable", busy_o, 0);
        test_en = 1;
        // R10: start together with abort is ignored
        start_set = 1; start_clr = 1;
        @(negedge clk);
        start_set = 0; start_clr = 0;
        chk(!busy_o, "R10 start with clr", busy_o, 0);

        // R4: address fill, seed ignored, fixed checksum, disturbed mid-run (R9)
        run_fill(2'b01, 3'd5, 1'b0, 8'h5C, 1'b1, "R4 R9 addr", cs1);
        chk(cs1 == 16'hF807, "R4 addr checksum F807", cs1, 16'hF807);
        run_fill(2'b11, 3'd0, 1'b1, 8'h33, 1'b0, "R4 addr alt", cs1);

        // R2 R3: random, repeatability
        run_fill(2'b00, 3'd0, 1'b1, 8'hA5, 1'b0, "R2 rand", cs1);
        run_fill(2'b00, 3'd0, 1'b0, 8'hA5, 1'b1, "R3 R9 rand repeat", cs2);
        chk(cs1 == cs2, "R3 same seed same checksum", cs2, cs1);
        // R3: zero seed
        run_fill(2'b00, 3'd2, 1'b0, 8'h00, 1'b0, "R3 zero seed", cs1);
        chk(cs1 == 16'hFFFF && seed_o == 8'h00, "R3 zero seed result", cs1, 16'hFFFF);

        // R5: shift fills, including shift 0 and checkerboard
        run_fill(2'b10, 3'd1, 1'b0, 8'hAA, 1'b0, "R5 shift1", cs1);
        run_fill(2'b10, 3'd0, 1'b1, 8'h96, 1'b0, "R5 shift0", cs1);
        run_fill(2'b10, 3'd3, 1'b1, 8'h81, 1'b0, "R5 shift3", cs1);

        // constrained random runs
        void'($urandom(32'hC0FFEE));
        for (int r = 0; r < 4; r++) begin
            logic [1:0] m;
            m = 2'($urandom % 3);
            run_fill(m, 3'($urandom), 1'($urandom), 8'($urandom), 1'($urandom), "R1 R8 random run", cs1);
        end

        // R7: abort with start_clr
        cs_prev = csum_o; seed_prev = seed_o;
        @(negedge clk);
        cfg_we = 1; cfg_mode = 2'b00; seed_we = 1; seed_wdata = 8'h3C;
        @(negedge clk);
        cfg_we = 0; seed_we = 0; start_set = 1;
        @(negedge clk);
        start_set = 0;
        repeat (50) @(negedge clk);
        start_clr = 1;
        #1;
        chk(!ram_a_we && !ram_b_we, "R7 no write in clr cycle", ram_a_we | ram_b_we, 0);
        @(negedge clk);
        start_clr = 0;
        chk(!busy_o, "R7 clr abort busy", busy_o, 1'b0);
        chk(csum_o == cs_prev && seed_o == 8'h3C, "R7 clr abort keeps csum/seed", csum_o, cs_prev);

        // R7: abort by dropping test_en
        start_set = 1;
        @(negedge clk);
        start_set = 0;
        repeat (20) @(negedge clk);
        test_en = 0;
        #1;
        chk(!ram_a_we && !ram_b_we, "R7 no write when enable low", ram_a_we | ram_b_we, 0);
        @(negedge clk);
        test_en = 1;
        chk(!busy_o && csum_o == cs_prev && seed_o == 8'h3C, "R7 enable abort", busy_o, 0);
        @(negedge clk);
        chk(!ram_a_we && !ram_b_we, "R7 stays idle", ram_a_we | ram_b_we, 0);
        if (seed_prev == 8'h00) begin end
        finish_run();
    end

    initial begin
        for (int c = 0; c < 190000; c++) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 190000, 0);
        finish_run();
    end
endmodule